// File: doc/BRIEF.md
# Power-of-two window input debouncer

This filter sits on one general-purpose pin, between the synchronized pad level and the logic that reports input state and raises edge interrupts. A glitchy level does not reach that logic. When filtering is on, a new level is accepted only after it has held, without interruption, for a whole window of millisecond ticks. The window length is a power of two, from 1 to 128 ms, chosen by a 3-bit code in the pin's control word.

When filtering is off, the level passes straight through in the same cycle. The millisecond strobe comes from a shared divider elsewhere on the chip and arrives as a one-cycle pulse. A change of the enable bit or of the window code restarts the filter. The output then takes the present raw level, so a reprogrammed pin does not keep a level that was half-qualified under the old window.

Top module: `pin_debounce`

## Requirements
- R1: With the enable bit (control bit 8) at 0, `level_out` equals `raw_in` in the same cycle, with no delay.
- R2: With the enable bit at 0, the window code and the control bits 4..0 have no effect on `level_out`.
- R3: With the enable bit at 1 and window code c in control bits 7..5, `level_out` takes a new raw level in the cycle after the clock edge that samples the 2^c-th tick during which `raw_in` differed from it without a break.
- R4: While enabled, one clock edge at which `raw_in` equals `level_out` discards the ticks already counted, so a full 2^c further ticks are needed.
- R5: Ticks seen while `raw_in` equals `level_out`, and cycles without a tick, add nothing toward the window.
- R6: A change of the enable bit or the window code, sampled at a clock edge, clears the tick count and loads the present `raw_in` into the filtered level at that edge.
- R7: During reset the filtered level is 0 and the count is cleared.
- R8: Every code from 0 (1 tick) to 7 (128 ticks) gives its exact window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| raw_in | input | 1 | Synchronized pin level |
| pin_ctrl | input | 9 | Pin control word: bit 8 enable, bits 7..5 window code |
| level_out | output | 1 | Filtered level |

## Verification
The bench goes after the off-by-one at each window edge. A counter that compared one step early or late would flip the output one tick too soon or too late, at 1, 4 and 128 ticks. A single matching cycle inside a run of differing ticks must start the count again. A design that only paused the count would then accept the level early. Cycles without a tick and ticks during a matching level must add nothing. A reprogrammed code must make the output jump to the raw level at once; a design that kept the old count would flip later. In the disabled state the output must follow the input at once, whatever the code bits hold.

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int CODE_W   = 3,
  parameter int RATE_LSB = 5,
  parameter int EN_BIT   = 8,
  parameter int CTRL_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              raw_in,
  input  logic [CTRL_W-1:0] pin_ctrl,
  output logic              level_out
);
  localparam int CNT_W = 2 ** CODE_W;

  logic              en;
  logic [CODE_W-1:0] code;
  logic [CODE_W:0]   cfg_q;
  logic              cfg_chg;
  logic [CNT_W-1:0]  win;
  logic [CNT_W-1:0]  cnt_q;
  logic              filt_q;
  logic              unused_ctrl;

  assign en          = pin_ctrl[EN_BIT];
  assign code        = pin_ctrl[RATE_LSB +: CODE_W];
  assign cfg_chg     = {en, code} != cfg_q;
  assign win         = CNT_W'(1) << code;
  assign level_out   = en ? filt_q : raw_in;
  assign unused_ctrl = ^pin_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cfg_q <= {en, code};
      if (cfg_chg || !en) begin
        filt_q <= raw_in;
        cnt_q  <= '0;
      end else if (raw_in == filt_q) begin
        cnt_q <= '0;
      end else if (tick_ms) begin
        if (cnt_q + 1'b1 == win) begin
          filt_q <= raw_in;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1
  bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> filt_q == $past(raw_in));

  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_chg && !tick_ms) |=> $stable(filt_q));

  // R4
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_chg && raw_in == filt_q) |=> cnt_q == '0);

  // R6
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt_q == '0 && filt_q == $past(raw_in)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_chg) |-> cnt_q < win);
endmodule

// File: tb/test_pin_debounce.sv
module test_pin_debounce;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       raw_in = 1'b0;
  logic [8:0] pin_ctrl = '0;
  logic       level_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  int m_cnt = 0;
  bit m_filt = 0;
  int m_prev = 0;

  always #4 clk = ~clk;

  pin_debounce i_pin_debounce (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_in(raw_in),
    .pin_ctrl(pin_ctrl), .level_out(level_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_out();
    return pin_ctrl[8] ? m_filt : raw_in;
  endfunction

  task automatic cyc();
    int cfg;
    int code;
    @(posedge clk);
    cfg  = int'(pin_ctrl[8:5]);
    code = int'(pin_ctrl[7:5]);
    if (!rst_n) begin
      m_cnt = 0; m_filt = 0; m_prev = 0;
    end else begin
      if (cfg != m_prev || !pin_ctrl[8]) begin
        m_filt = raw_in; m_cnt = 0;
      end else if (raw_in == m_filt) begin
        m_cnt = 0;
      end else if (tick_ms) begin
        m_cnt++;
        if (m_cnt == (1 << code)) begin m_filt = raw_in; m_cnt = 0; end
      end
      m_prev = cfg;
    end
    #1;
    chk(pin_ctrl[8] ? "R3 model" : "R1 model", level_out, model_out());
  endtask

  task automatic run(input int n, input logic tk);
    tick_ms = tk;
    for (int i = 0; i < n; i++) cyc();
    tick_ms = 1'b0;
  endtask

  task automatic setcfg(input logic en, input int code);
    pin_ctrl = {en, 3'(code), 5'b0};
    run(1, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    run(3, 1'b0);
    chk("R7 reset level", level_out, 1'b0);
    pin_ctrl = 9'h100;
    raw_in = 1'b1;
    #1 chk("R7 reset filtered level", level_out, 1'b0);
    raw_in = 1'b0;
    rst_n = 1'b1;
    run(2, 1'b0);

    // R1 bypass
    setcfg(1'b0, 0);
    raw_in = 1'b1; #1 chk("R1 bypass high", level_out, 1'b1);
    raw_in = 1'b0; #1 chk("R1 bypass low", level_out, 1'b0);
    // R2 code and low bits ignored when disabled
    pin_ctrl = 9'b0_101_11011;
    raw_in = 1'b1; #1 chk("R2 code ignored", level_out, 1'b1);
    run(2, 1'b1);
    raw_in = 1'b0; #1 chk("R2 low bits ignored", level_out, 1'b0);
    run(1, 1'b0);

    // R3 window of 4 ticks
    setcfg(1'b1, 2);
    raw_in = 1'b1;
    run(3, 1'b1);
    chk("R3 before 4th tick", level_out, 1'b0);
    run(1, 1'b1);
    chk("R3 at 4th tick", level_out, 1'b1);

    // R4 restart on a matching cycle
    raw_in = 1'b0; run(3, 1'b1);
    raw_in = 1'b1; run(1, 1'b1);
    raw_in = 1'b0; run(3, 1'b1);
    chk("R4 count restarted", level_out, 1'b1);
    run(1, 1'b1);
    chk("R4 full window after restart", level_out, 1'b0);

    // R5 idle cycles and matching ticks add nothing
    run(10, 1'b1);
    raw_in = 1'b1;
    run(6, 1'b0);
    run(3, 1'b1);
    chk("R5 only differing ticks count", level_out, 1'b0);
    run(1, 1'b0);
    chk("R5 idle cycle no count", level_out, 1'b0);
    run(1, 1'b1);
    chk("R5 fourth differing tick", level_out, 1'b1);

    // R6 reprogramming restarts and loads raw
    setcfg(1'b1, 3);
    raw_in = 1'b0;
    run(5, 1'b1);
    chk("R6 mid window", level_out, 1'b1);
    pin_ctrl = {1'b1, 3'd2, 5'b0};
    run(1, 1'b0);
    chk("R6 code change loads raw", level_out, 1'b0);
    raw_in = 1'b1;
    run(3, 1'b1);
    chk("R6 fresh count after change", level_out, 1'b0);
    pin_ctrl = 9'h000; run(1, 1'b0);
    pin_ctrl = {1'b1, 3'd2, 5'b0}; run(1, 1'b0);
    chk("R6 enable toggle loads raw", level_out, 1'b1);

    // R8 range ends
    setcfg(1'b1, 0);
    raw_in = 1'b0;
    run(1, 1'b1);
    chk("R8 code 0 one tick", level_out, 1'b0);
    setcfg(1'b1, 7);
    raw_in = 1'b1;
    for (int i = 0; i < 127; i++) begin run(1, 1'b1); run(1, 1'b0); end
    chk("R8 code 7 before 128th", level_out, 1'b0);
    run(1, 1'b1);
    chk("R8 code 7 at 128th", level_out, 1'b1);
    raw_in = 1'b0;
    run(128, 1'b1);
    chk("R8 code 7 back low", level_out, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule